// File: doc/BRIEF.md
# Core Board Control Register File

This block is the control and configuration register set of a processor core board. It sits on a simple 32-bit bus with word addressing: the word index is taken from the byte address with bits [1:0] dropped. It offers these functions:

- fixed identity and status words;
- two clock-generator settings, which can be written only after a 16-bit key is loaded;
- a control word that drives a board LED, selects whether boot memory appears at address zero, and can request a system reset;
- two flag words, one cleared by a reset request and one that survives it, each with separate set and clear addresses;
- memory-timing and initialisation words;
- a small software-interrupt mask section.

A read-only window returns one byte per word from a memory-module presence-detect table. The software interrupt bit and its two enable masks are visible only through the bus.

Reads are combinational from the current register state. A write takes effect at the rising clock edge on which `bus_en` and `bus_we` are both high. The asynchronous reset is released through a two-stage synchroniser, so the registers leave reset on the second rising edge after `rst_n` goes high.

Top module: `cm_regfile`

## Requirements
- R1: Word index 0 reads 0x411A3001, index 1 reads 0, and index 4 reads 0x00100000. Writes to these indices have no effect.
- R2: After reset the following values hold:
  - index 2 reads 0x01000048 and index 7 reads 0x0007FEFF;
  - index 9 reads 0x00000112;
  - index 8 reads 0x00011122 ORed with a size code taken from `MEM_MB`: 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, else 0;
  - the control word, both flag words, both enable masks, the soft bit and the key all read 0.
- R3: A write to index 5 keeps only data bits [15:0]. When the kept value is 0xA05F, index 5 reads 0x0001A05F; otherwise it reads the kept value with zeros above bit 15.
- R4: Writes to index 2 and index 7 replace the stored word only while the key at index 5 equals 0xA05F. At any other time they are ignored.
- R5: A write to index 3 stores only data bits 0 and 2, and index 3 reads them back with all other bits 0. If data bit 3 is 1, `sys_rst_req` is high for exactly the one cycle after that write edge.
- R6: `boot_at_zero` is high while stored control bit 2 is 0 and low while it is 1. `led` follows stored control bit 0.
- R7: The flag word behaves as follows:
  - index 12 reads it, and a write there ORs the data into it;
  - a write to index 13 clears the bits that are 1 in the data.
  - Indices 14 and 15 do the same for the persistent flag word. Indices 13 and 15 read 0.
- R8: A reset request (control write with bit 3 set) clears the flag word to 0 at the same edge, and leaves the persistent flag word unchanged.
- R9: Index 8 and index 9 take any written 32-bit value.
- R10: The presence-detect window behaves as follows:
  - byte addresses 0x100 to 0x17F read, in bits [7:0], the table byte numbered address>>2 (64 to 95);
  - table bytes 73 to 83 hold the ASCII text "SDRAM-CORE1" in order, and all other bytes in that range are 0;
  - addresses 0x180 to 0x1FF read 0;
  - writes anywhere from 0x100 to 0x1FF are ignored.
- R11: The IRQ part of the interrupt section works as follows:
  - raw level is soft bit 0;
  - index 17 reads the raw level, and index 16 reads the raw level ANDed with the IRQ mask;
  - index 18 reads the IRQ mask and ORs data into it, and index 19 clears the mask bits that are 1 in the data;
  - a write to index 20 with data bit 0 set raises the soft bit, and a write to index 21 with data bit 0 set lowers it;
  - index 20 reads the soft bit, and index 21 reads 0.
- R12: Indices 24, 25, 26 and 27 behave as 16, 17, 18 and 19 do, using a separate FIQ mask.
- R13: Every other index below 0x100, including indices 32 to 35, and every address from 0x200 upward reads 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when no read is in progress |
| sys_rst_req | output | 1 | One-cycle system reset request pulse |
| boot_at_zero | output | 1 | High while boot memory is mapped at address zero |
| led | output | 1 | Board LED drive |

## Verification
Assertions check the following on every cycle:
- the reset pulse lasts one cycle and always follows a control write with bit 3 set;
- `boot_at_zero` moves only after a control write;
- the clock words change only while the key is loaded;
- the set/clear words change only on their own strobes;
- the key readback status bit agrees with the key comparison;
- reads above 0x1FF return 0.

The bench runs scenarios and compares them against an arithmetic model. It sweeps every word address below 0x200 plus several higher ones after each scenario. The scenarios cover:
- the exact reset values;
- the key lifecycle;
- flag persistence across a reset request;
- the set-over-clear interplay of the masks;
- the contents of the presence-detect window;
- the claim that stray writes leave every register unchanged.

// File: rtl/cm_pkg.sv
package cm_pkg;

  typedef logic [5:0] ridx_t;

  localparam ridx_t RX_ID       = 6'd0;
  localparam ridx_t RX_OSC      = 6'd2;
  localparam ridx_t RX_CTRL     = 6'd3;
  localparam ridx_t RX_STAT     = 6'd4;
  localparam ridx_t RX_LOCK     = 6'd5;
  localparam ridx_t RX_AUX      = 6'd7;
  localparam ridx_t RX_SDRAM    = 6'd8;
  localparam ridx_t RX_INIT     = 6'd9;
  localparam ridx_t RX_FLG_SET  = 6'd12;
  localparam ridx_t RX_FLG_CLR  = 6'd13;
  localparam ridx_t RX_NV_SET   = 6'd14;
  localparam ridx_t RX_NV_CLR   = 6'd15;
  localparam ridx_t RX_IRQ_ST   = 6'd16;
  localparam ridx_t RX_IRQ_RAW  = 6'd17;
  localparam ridx_t RX_IRQ_ENS  = 6'd18;
  localparam ridx_t RX_IRQ_ENC  = 6'd19;
  localparam ridx_t RX_SOFT_SET = 6'd20;
  localparam ridx_t RX_SOFT_CLR = 6'd21;
  localparam ridx_t RX_FIQ_ST   = 6'd24;
  localparam ridx_t RX_FIQ_RAW  = 6'd25;
  localparam ridx_t RX_FIQ_ENS  = 6'd26;
  localparam ridx_t RX_FIQ_ENC  = 6'd27;

  localparam logic [31:0] BOARD_ID   = 32'h411A3001;
  localparam logic [31:0] STAT_VAL   = 32'h00100000;
  localparam logic [31:0] OSC_INIT   = 32'h01000048;
  localparam logic [31:0] AUX_INIT   = 32'h0007FEFF;
  localparam logic [31:0] INIT_INIT  = 32'h00000112;
  localparam logic [31:0] SDRAM_BASE = 32'h00011122;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  function automatic logic [31:0] sdram_size_code(input int mb);
    if (mb >= 256)     return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

endpackage

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
  parameter int W        = 32,
  parameter bit SOFT_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic         soft_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic         soft_hit;
  logic         upd;
  logic [W-1:0] q_d;

  generate
    if (SOFT_CLR) begin : g_soft
      assign soft_hit = soft_clr;
    end else begin : g_keep
      logic unused_soft;
      assign unused_soft = soft_clr;
      assign soft_hit    = 1'b0;
    end
  endgenerate

  always_comb begin
    q_d = q;
    if (set_en)   q_d = q_d | wdata;
    if (clr_en)   q_d = q_d & ~wdata;
    if (soft_hit) q_d = '0;
  end

  assign upd = set_en | clr_en | soft_hit;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)  q <= '0;
    else if (upd) q <= q_d;
  end

  // R7
  setclr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(q) |-> $past(set_en || clr_en || soft_hit));

endmodule

// File: rtl/cm_keyed_osc.sv
module cm_keyed_osc #(
  parameter logic [15:0] KEY      = 16'hA05F,
  parameter logic [31:0] OSC_RST  = 32'h0,
  parameter logic [31:0] AUX_RST  = 32'h0
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        lock_we,
  input  logic        osc_we,
  input  logic        aux_we,
  input  logic [31:0] wdata,
  output logic        open_o,
  output logic [15:0] lock_o,
  output logic [31:0] osc_o,
  output logic [31:0] aux_o
);

  logic osc_upd, aux_upd;

  assign open_o  = (lock_o == KEY);
  assign osc_upd = osc_we & open_o;
  assign aux_upd = aux_we & open_o;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      lock_o <= '0;
    else if (lock_we) lock_o <= wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      osc_o <= OSC_RST;
    else if (osc_upd) osc_o <= wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      aux_o <= AUX_RST;
    else if (aux_upd) aux_o <= wdata;
  end

  // R4
  osc_guard_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(osc_o) |-> $past(lock_o == KEY));

  // R4
  aux_guard_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(aux_o) |-> $past(lock_o == KEY));

endmodule

// File: rtl/cm_spd_win.sv
module cm_spd_win #(
  parameter int                      IDENT_LEN = 11,
  parameter logic [8*IDENT_LEN-1:0]  IDENT     = "SDRAM-CORE1",
  parameter int                      IDENT_POS = 73
) (
  input  logic [6:0] bidx,
  output logic [7:0] byte_o
);

  int k;

  always_comb begin
    k      = int'(bidx) - IDENT_POS;
    byte_o = 8'h00;
    if (k >= 0 && k < IDENT_LEN)
      byte_o = IDENT[8*(IDENT_LEN-1-k) +: 8];
  end

endmodule

// File: rtl/cm_regfile.sv
module cm_regfile #(
  parameter int AW     = 12,
  parameter int MEM_MB = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          sys_rst_req,
  output logic          boot_at_zero,
  output logic          led
);
  import cm_pkg::*;

  localparam logic [31:0]   SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);
  localparam logic [AW-9:0] HI_SPD    = 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // address decode
  ridx_t idx;
  logic  lo_reg, spd_reg, rd_en, wr_lo;
  logic  unused_lo;
  assign idx       = bus_addr[7:2];
  assign lo_reg    = (bus_addr[AW-1:8] == '0);
  assign spd_reg   = (bus_addr[AW-1:8] == HI_SPD);
  assign rd_en     = bus_en & ~bus_we;
  assign wr_lo     = bus_en & bus_we & lo_reg;
  assign unused_lo = ^bus_addr[1:0];

  logic ctrl_we, lock_we, osc_we, aux_we, sdram_we, init_we;
  logic fs_we, fc_we, ns_we, nc_we, is_we, ic_we, qs_we, qc_we, ss_we, sc_we;
  assign ctrl_we  = wr_lo && idx == RX_CTRL;
  assign lock_we  = wr_lo && idx == RX_LOCK;
  assign osc_we   = wr_lo && idx == RX_OSC;
  assign aux_we   = wr_lo && idx == RX_AUX;
  assign sdram_we = wr_lo && idx == RX_SDRAM;
  assign init_we  = wr_lo && idx == RX_INIT;
  assign fs_we    = wr_lo && idx == RX_FLG_SET;
  assign fc_we    = wr_lo && idx == RX_FLG_CLR;
  assign ns_we    = wr_lo && idx == RX_NV_SET;
  assign nc_we    = wr_lo && idx == RX_NV_CLR;
  assign is_we    = wr_lo && idx == RX_IRQ_ENS;
  assign ic_we    = wr_lo && idx == RX_IRQ_ENC;
  assign qs_we    = wr_lo && idx == RX_FIQ_ENS;
  assign qc_we    = wr_lo && idx == RX_FIQ_ENC;
  assign ss_we    = wr_lo && idx == RX_SOFT_SET && bus_wdata[0];
  assign sc_we    = wr_lo && idx == RX_SOFT_CLR && bus_wdata[0];

  // control word, reset request pulse
  logic led_q, remap_q, req_q;
  logic led_d, remap_d, req_d;
  logic rst_hit;
  assign rst_hit = ctrl_we & bus_wdata[3];

  always_comb begin
    led_d   = led_q;
    remap_d = remap_q;
    if (ctrl_we) begin
      led_d   = bus_wdata[0];
      remap_d = bus_wdata[2];
    end
    req_d = rst_hit;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      led_q   <= 1'b0;
      remap_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= req_d;
      if (ctrl_we) begin
        led_q   <= led_d;
        remap_q <= remap_d;
      end
    end
  end

  assign sys_rst_req  = req_q;
  assign boot_at_zero = ~remap_q;
  assign led          = led_q;

  // plain words and soft interrupt level
  logic [31:0] sdram_q, init_q;
  logic        soft_q, soft_d;

  always_comb begin
    soft_d = soft_q;
    if (ss_we) soft_d = 1'b1;
    if (sc_we) soft_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sdram_q <= SDRAM_RST;
      init_q  <= INIT_INIT;
      soft_q  <= 1'b0;
    end else begin
      if (sdram_we)       sdram_q <= bus_wdata;
      if (init_we)        init_q  <= bus_wdata;
      if (ss_we || sc_we) soft_q  <= soft_d;
    end
  end

  // keyed clock settings
  logic        lock_open;
  logic [15:0] lock_q;
  logic [31:0] osc_q, aux_q;

  cm_keyed_osc #(
    .KEY(UNLOCK_KEY), .OSC_RST(OSC_INIT), .AUX_RST(AUX_INIT)
  ) u_osc (
    .clk(clk), .rst_ni(rst_i),
    .lock_we(lock_we), .osc_we(osc_we), .aux_we(aux_we),
    .wdata(bus_wdata),
    .open_o(lock_open), .lock_o(lock_q), .osc_o(osc_q), .aux_o(aux_q)
  );

  // set/clear words
  logic [31:0] flags_q, nv_q, ien_q, fen_q;

  cm_setclr_reg #(.W(32), .SOFT_CLR(1'b1)) u_flags (
    .clk(clk), .rst_ni(rst_i), .set_en(fs_we), .clr_en(fc_we),
    .soft_clr(rst_hit), .wdata(bus_wdata), .q(flags_q));

  cm_setclr_reg #(.W(32), .SOFT_CLR(1'b0)) u_nvflags (
    .clk(clk), .rst_ni(rst_i), .set_en(ns_we), .clr_en(nc_we),
    .soft_clr(rst_hit), .wdata(bus_wdata), .q(nv_q));

  cm_setclr_reg #(.W(32), .SOFT_CLR(1'b0)) u_irq_en (
    .clk(clk), .rst_ni(rst_i), .set_en(is_we), .clr_en(ic_we),
    .soft_clr(1'b0), .wdata(bus_wdata), .q(ien_q));

  cm_setclr_reg #(.W(32), .SOFT_CLR(1'b0)) u_fiq_en (
    .clk(clk), .rst_ni(rst_i), .set_en(qs_we), .clr_en(qc_we),
    .soft_clr(1'b0), .wdata(bus_wdata), .q(fen_q));

  // presence-detect window
  logic [7:0] spd_byte;
  cm_spd_win u_spd (.bidx(bus_addr[8:2]), .byte_o(spd_byte));

  // read mux
  logic [31:0] raw_lvl, lo_rd;
  assign raw_lvl = {31'b0, soft_q};

  always_comb begin
    lo_rd = '0;
    case (idx)
      RX_ID:       lo_rd = BOARD_ID;
      RX_OSC:      lo_rd = osc_q;
      RX_CTRL:     lo_rd = {29'b0, remap_q, 1'b0, led_q};
      RX_STAT:     lo_rd = STAT_VAL;
      RX_LOCK:     lo_rd = {15'b0, lock_open, lock_q};
      RX_AUX:      lo_rd = aux_q;
      RX_SDRAM:    lo_rd = sdram_q;
      RX_INIT:     lo_rd = init_q;
      RX_FLG_SET:  lo_rd = flags_q;
      RX_NV_SET:   lo_rd = nv_q;
      RX_IRQ_ST:   lo_rd = raw_lvl & ien_q;
      RX_IRQ_RAW:  lo_rd = raw_lvl;
      RX_IRQ_ENS:  lo_rd = ien_q;
      RX_SOFT_SET: lo_rd = raw_lvl;
      RX_FIQ_ST:   lo_rd = raw_lvl & fen_q;
      RX_FIQ_RAW:  lo_rd = raw_lvl;
      RX_FIQ_ENS:  lo_rd = fen_q;
      default:     lo_rd = '0;
    endcase
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (lo_reg)                      bus_rdata = lo_rd;
      else if (spd_reg && !bus_addr[7]) bus_rdata = {24'b0, spd_byte};
    end
  end

  // R5
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    sys_rst_req |=> !sys_rst_req);

  // R5
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_i)
    sys_rst_req |-> $past(ctrl_we && bus_wdata[3]));

  // R6
  remap_cause_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(boot_at_zero) |-> $past(ctrl_we));

  // R3
  lock_status_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_en && lo_reg && idx == RX_LOCK) |-> (bus_rdata[16] == (lock_q == UNLOCK_KEY)));

  // R13
  high_zero_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_en && !lo_reg && !spd_reg) |-> (bus_rdata == 32'h0));

endmodule

// File: tb/sim_cm_regfile.sv
module sim_cm_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_req, boot_at_zero, led;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  cm_regfile #(.AW(12), .MEM_MB(128)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req), .boot_at_zero(boot_at_zero), .led(led));

  // reference model
  logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flags, m_nv, m_ien, m_fen, m_ctrl;
  logic [15:0] m_lock;
  logic        m_soft;
  logic [87:0] ident = "SDRAM-CORE1";

  task automatic model_reset();
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF;
    m_sdram = 32'h0001112E; m_init = 32'h00000112;
    m_flags = 0; m_nv = 0; m_ien = 0; m_fen = 0; m_ctrl = 0;
    m_lock = 0; m_soft = 0;
  endtask

  function automatic logic [31:0] exp_rd(input int a);
    int i;
    i = a >> 2;
    if (a >= 'h200) return 0;
    if (a >= 'h180) return 0;
    if (a >= 'h100) begin
      if (i >= 73 && i <= 83) return {24'b0, ident[8*(83-i) +: 8]};
      return 0;
    end
    case (i)
      0:  return 32'h411A3001;
      2:  return m_osc;
      3:  return m_ctrl;
      4:  return 32'h00100000;
      5:  return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'b0, m_lock};
      7:  return m_aux;
      8:  return m_sdram;
      9:  return m_init;
      12: return m_flags;
      14: return m_nv;
      16: return {31'b0, m_soft & m_ien[0]};
      17, 20, 25: return {31'b0, m_soft};
      18: return m_ien;
      24: return {31'b0, m_soft & m_fen[0]};
      26: return m_fen;
      default: return 0;
    endcase
  endfunction

  function automatic string tag(input int a);
    int i;
    i = a >> 2;
    if (a >= 'h200) return "R13";
    if (a >= 'h100) return "R10";
    case (i)
      0, 1, 4: return "R1";
      2, 7: return "R4";
      3: return "R5";
      5: return "R3";
      8, 9: return "R9";
      12, 13, 14, 15: return "R7";
      16, 17, 18, 19, 20, 21: return "R11";
      24, 25, 26, 27: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    int i;
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a[11:0]; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    i = a >> 2;
    if (a < 'h100) begin
      case (i)
        2:  if (m_lock == 16'hA05F) m_osc = d;
        3:  begin m_ctrl = d & 32'h5; if (d[3]) m_flags = 0; end
        5:  m_lock = d[15:0];
        7:  if (m_lock == 16'hA05F) m_aux = d;
        8:  m_sdram = d;
        9:  m_init = d;
        12: m_flags = m_flags | d;
        13: m_flags = m_flags & ~d;
        14: m_nv = m_nv | d;
        15: m_nv = m_nv & ~d;
        18: m_ien = m_ien | d;
        19: m_ien = m_ien & ~d;
        20: if (d[0]) m_soft = 1;
        21: if (d[0]) m_soft = 0;
        26: m_fen = m_fen | d;
        27: m_fen = m_fen & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic rd_chk(input int a, input string req);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a[11:0];
    #1;
    chk(req, bus_rdata, exp_rd(a), $sformatf("read 0x%03h", a));
    bus_en = 0;
  endtask

  task automatic chk_pins(input string req);
    #1;
    chk(req, {29'b0, sys_rst_req, boot_at_zero, led},
        {29'b0, 1'b0, ~m_ctrl[2], m_ctrl[0]}, "req/boot/led pins");
  endtask

  task automatic sweep();
    for (int a = 0; a < 'h200; a += 4) rd_chk(a, tag(a));
    rd_chk('h200, "R13");
    rd_chk('h400, "R13");
    rd_chk('hFFC, "R13");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2: reset state everywhere
    chk_pins("R2");
    for (int a = 0; a < 'h100; a += 4) rd_chk(a, "R2");
    sweep();

    // R4: keyed words ignore writes while locked
    wr('h008, 32'hDEADBEEF);
    wr('h01C, 32'h12345678);
    rd_chk('h008, "R4"); rd_chk('h01C, "R4");
    // R3: only low half kept, status bit when key matches
    wr('h014, 32'hFFFF1234); rd_chk('h014, "R3");
    wr('h014, 32'h5A5AA05F); rd_chk('h014, "R3");
    wr('h008, 32'hCAFEF00D); wr('h01C, 32'h0BADC0DE);
    rd_chk('h008, "R4"); rd_chk('h01C, "R4");
    wr('h014, 32'h0000A05E); rd_chk('h014, "R3");
    wr('h008, 32'h11111111); rd_chk('h008, "R4");

    // R5/R6: control storage and pins
    wr('h00C, 32'hFFFFFFF7); rd_chk('h00C, "R5"); chk_pins("R6");
    wr('h00C, 32'h00000001); chk_pins("R6");
    wr('h00C, 32'h00000004); chk_pins("R6");
    wr('h00C, 32'h00000000); chk_pins("R6");

    // R7: flag set/clear patterns
    for (int p = 0; p < 8; p++) begin
      wr('h030, 32'h1 << (p * 4));
      wr('h038, 32'h80000000 >> (p * 3));
      if (p % 3 == 2) begin wr('h034, 32'h0F0F0F0F); wr('h03C, 32'hF0F0F0F0); end
      rd_chk('h030, "R7"); rd_chk('h038, "R7");
      rd_chk('h034, "R7"); rd_chk('h03C, "R7");
    end
    wr('h030, 32'hA5A5A5A5); wr('h038, 32'h5A5A5A5A);

    // R8 and R5: reset request pulse, flags cleared, persistent kept
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 12'h00C; bus_wdata = 32'h0000000D;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    m_ctrl = 32'h5; m_flags = 0;
    #1 chk("R5", {31'b0, sys_rst_req}, 32'h1, "reset request pulse high");
    rd_chk('h00C, "R5");
    chk("R5", {31'b0, sys_rst_req}, 32'h0, "reset request pulse one cycle");
    rd_chk('h030, "R8"); rd_chk('h038, "R8");
    chk_pins("R6");
    wr('h00C, 32'h0);

    // R9
    wr('h020, 32'h89ABCDEF); wr('h024, 32'h76543210);
    rd_chk('h020, "R9"); rd_chk('h024, "R9");

    // R11/R12: interrupt masks and soft level
    wr('h050, 32'h00000002); rd_chk('h040, "R11"); rd_chk('h044, "R11");
    wr('h048, 32'hF00000F1); rd_chk('h040, "R11"); rd_chk('h048, "R11");
    wr('h068, 32'h0000FFFF); rd_chk('h060, "R12"); rd_chk('h068, "R12");
    wr('h050, 32'hFFFFFFFF); rd_chk('h040, "R11"); rd_chk('h044, "R11");
    rd_chk('h050, "R11"); rd_chk('h060, "R12"); rd_chk('h064, "R12");
    wr('h06C, 32'h00000001); rd_chk('h060, "R12"); rd_chk('h068, "R12");
    wr('h04C, 32'h00000001); rd_chk('h040, "R11"); rd_chk('h048, "R11");
    wr('h054, 32'h00000000); rd_chk('h044, "R11");
    wr('h054, 32'h00000001); rd_chk('h044, "R11"); rd_chk('h064, "R12");
    wr('h050, 32'h1);
    sweep();

    // R13 and R10: stray writes change nothing
    foreach (ident[j]) ;
    for (int a = 0; a < 'h100; a += 4) begin
      int i = a >> 2;
      if (!(i inside {2,3,5,7,8,9,12,13,14,15,18,19,20,21,26,27}))
        wr(a, 32'hFFFFFFFF);
    end
    for (int a = 'h100; a < 'h200; a += 'h14) wr(a, 32'hFFFFFFFF);
    wr('h200, 32'hFFFFFFFF); wr('hFFC, 32'hFFFFFFFF);
    chk_pins("R13");
    sweep();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule